// File: doc/BRIEF.md
# Global 64-bit Timer with Comparator

This block is a memory-mapped system timer. It holds a 64-bit up-counter that can be started and stopped, and one 64-bit comparator. When the comparator is enabled and the counter equals its value, an interrupt-pending flag is raised. With auto-increment switched on, the comparator adds a programmed 32-bit step to itself on every match. The interrupt then repeats at a fixed period, and software never has to reload the comparator.

Software reaches the block over a plain 32-bit register bus. A write takes effect at the clock edge on which it is presented. A read is combinational from the address. Every write to the counter, comparator, step or control register later sets its own write-1-to-clear confirmation bit, a fixed number of cycles after the write. Software polls that bit to learn that the write has landed. The whole block runs on the bus clock.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq` is low.
- R2: While control bit 8 (offset 0x240) is 1, the counter rises by exactly 1 per clock. The low word carries into the high word, and the all-ones value wraps to 0. While bit 8 is 0, the counter holds its value.
- R3: A write to offset 0x100 replaces the counter's low 32 bits and a write to 0x104 replaces its high 32 bits. The other half keeps its value, and both words read back live at those offsets.
- R4: When control bit 0 is 1 and the counter equals the comparator ({0x204 high, 0x200 low}), pending bit 0 at 0x244 reads 1 from the next cycle on. When control bit 0 is 0, a counter equal to the comparator leaves the pending bit at 0.
- R5: When control bits 0 and 1 are both 1, each match adds the step at 0x208 (zero-extended) to the comparator, modulo 2^64. The next match then comes exactly one step later.
- R6: Writing 1 to bit 0 of 0x244 clears the pending bit, and writing 0 there leaves it unchanged.
- R7: `irq` is high exactly when the pending bit and enable bit 0 at 0x248 are both 1.
- R8: Writes to 0x100 and 0x104 set bits 0 and 1 of 0x110. Writes to 0x200, 0x204 and 0x208 set bits 0, 1 and 2 of 0x24C, and a write to 0x240 sets bit 16 of 0x24C. A write presented in cycle c sets its bit so that it reads 0 in cycle c+1 and 1 in cycle c+WDLY (WDLY=2). The bit then stays set until it is cleared.
- R9: Writing 1 to a write-status bit clears it, and a 0 in that bit position leaves it set.
- R10: The control register reads back only bits 8, 1 and 0, the step and comparator read back as written, and offsets outside the map read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt: pending AND enable |

## Verification
The hardest case to reach from the ports is a match near the top of the 64-bit range. There the auto-increment must wrap the comparator through zero, and the counter must carry across both words. The stimulus stops the counter first. It then writes the counter and the comparator a few counts below all-ones, and only after that starts the counter with auto-increment on. This makes the wrap land on a cycle the bench can predict. The write-status timing is checked by reading the status word both one and two cycles after a write.

// File: rtl/gtimer_cmp.sv
module gtimer_cmp #(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int WDLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int CW   = 2 * DW;
  localparam int NW   = 6;
  localparam int NSTG = WDLY - 1;

  localparam logic [AW-1:0] A_CNT_LO = AW'(12'h100);
  localparam logic [AW-1:0] A_CNT_HI = AW'(12'h104);
  localparam logic [AW-1:0] A_CWS    = AW'(12'h110);
  localparam logic [AW-1:0] A_CMP_LO = AW'(12'h200);
  localparam logic [AW-1:0] A_CMP_HI = AW'(12'h204);
  localparam logic [AW-1:0] A_STEP   = AW'(12'h208);
  localparam logic [AW-1:0] A_CTL    = AW'(12'h240);
  localparam logic [AW-1:0] A_PEND   = AW'(12'h244);
  localparam logic [AW-1:0] A_IEN    = AW'(12'h248);
  localparam logic [AW-1:0] A_GWS    = AW'(12'h24C);

  logic [CW-1:0] cnt, cmp;
  logic [DW-1:0] step;
  logic          run, cmp_on, auto_on, pend, ien;
  logic [1:0]    cws;
  logic [3:0]    gws;

  wire w_cnt_lo = bus_we && bus_addr == A_CNT_LO;
  wire w_cnt_hi = bus_we && bus_addr == A_CNT_HI;
  wire w_cws    = bus_we && bus_addr == A_CWS;
  wire w_cmp_lo = bus_we && bus_addr == A_CMP_LO;
  wire w_cmp_hi = bus_we && bus_addr == A_CMP_HI;
  wire w_step   = bus_we && bus_addr == A_STEP;
  wire w_ctl    = bus_we && bus_addr == A_CTL;
  wire w_pend   = bus_we && bus_addr == A_PEND;
  wire w_ien    = bus_we && bus_addr == A_IEN;
  wire w_gws    = bus_we && bus_addr == A_GWS;

  wire [NW-1:0] wr_hit = {w_ctl, w_step, w_cmp_hi, w_cmp_lo, w_cnt_hi, w_cnt_lo};
  wire          match  = cmp_on && (cnt == cmp);

  logic [NW-1:0] stg [NSTG];
  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= wr_hit;
  end
  for (genvar i = 1; i < NSTG; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end
  wire [NW-1:0] landed = stg[NSTG-1];

  wire [1:0] cws_clr = w_cws ? bus_wdata[1:0] : 2'b00;
  wire [3:0] gws_clr = w_gws ? {bus_wdata[16], bus_wdata[2:0]} : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cws <= '0;
      gws <= '0;
    end else begin
      cws <= (cws & ~cws_clr) | landed[1:0];
      gws <= (gws & ~gws_clr) | landed[5:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (w_cnt_lo) cnt[DW-1:0] <= bus_wdata;
    else if (w_cnt_hi) cnt[CW-1:DW] <= bus_wdata;
    else if (run)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cmp <= '0;
    else if (w_cmp_lo)         cmp[DW-1:0] <= bus_wdata;
    else if (w_cmp_hi)         cmp[CW-1:DW] <= bus_wdata;
    else if (match && auto_on) cmp <= cmp + CW'(step);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= '0;
      run     <= 1'b0;
      cmp_on  <= 1'b0;
      auto_on <= 1'b0;
      ien     <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (w_step) step <= bus_wdata;
      if (w_ctl) begin
        run     <= bus_wdata[8];
        auto_on <= bus_wdata[1];
        cmp_on  <= bus_wdata[0];
      end
      if (w_ien) ien <= bus_wdata[0];
      pend <= (pend & ~(w_pend & bus_wdata[0])) | match;
    end
  end

  assign irq = pend & ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[DW-1:0];
      A_CNT_HI: bus_rdata = cnt[CW-1:DW];
      A_CWS:    bus_rdata = DW'(cws);
      A_CMP_LO: bus_rdata = cmp[DW-1:0];
      A_CMP_HI: bus_rdata = cmp[CW-1:DW];
      A_STEP:   bus_rdata = step;
      A_CTL:    bus_rdata = DW'({run, 6'b0, auto_on, cmp_on});
      A_PEND:   bus_rdata = DW'(pend);
      A_IEN:    bus_rdata = DW'(ien);
      A_GWS:    bus_rdata = DW'({gws[3], 13'b0, gws[2:0]});
      default:  bus_rdata = '0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !w_cnt_lo && !w_cnt_hi) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !w_cnt_lo && !w_cnt_hi) |=> $stable(cnt)); // R2
  AST_MATCH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_on && cnt == cmp) |=> pend); // R4
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_on && !w_cmp_lo && !w_cmp_hi) |=> cmp == $past(cmp) + CW'($past(step))); // R5
  AST_WS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cws[0] && !(w_cws && bus_wdata[0])) |=> cws[0]); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> !irq); // R7
endmodule

// File: tb/sim_gtimer_cmp.sv
module sim_gtimer_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];

  gtimer_cmp u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic chk(logic [11:0] a, logic [31:0] e, string tag);
    bus_addr = a;
    #1;
    exp_q.push_back(e); tag_q.push_back(tag); act_q.push_back(bus_rdata);
  endtask

  task automatic chk_irq(logic e, string tag);
    exp_q.push_back({31'b0, e}); tag_q.push_back(tag); act_q.push_back({31'b0, irq});
  endtask

  initial begin : monitor
    forever begin
      wait (act_q.size() != 0);
      begin
        logic [31:0] a, e;
        string t;
        a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    tick(2);
    rst_n = 1'b1;
    tick();
    chk(12'h100, 0, "R1 cnt lo");
    chk(12'h104, 0, "R1 cnt hi");
    chk(12'h240, 0, "R1 ctl");
    chk(12'h244, 0, "R1 pend");
    chk(12'h24C, 0, "R1 gws");
    chk_irq(1'b0, "R1 irq");
    tick(3);
    chk(12'h100, 0, "R1 stopped");

    wr(12'h110, 32'h3); tick();
    wr(12'h100, 32'hFFFF_FFFE);
    chk(12'h110, 32'h0, "R8 status one cycle after write");
    tick();
    chk(12'h110, 32'h1, "R8 status two cycles after write");
    wr(12'h104, 32'h0);
    tick();
    chk(12'h110, 32'h3, "R8 hi status");
    wr(12'h110, 32'h0);
    chk(12'h110, 32'h3, "R9 write 0 keeps");
    wr(12'h110, 32'h1);
    chk(12'h110, 32'h2, "R9 clear bit0 only");
    chk(12'h100, 32'hFFFF_FFFE, "R3 lo readback");
    chk(12'h104, 32'h0, "R3 hi kept");

    wr(12'h240, 32'h100);
    tick(2);
    chk(12'h100, 32'h0, "R2 carry lo");
    chk(12'h104, 32'h1, "R2 carry hi");
    wr(12'h240, 32'h0);
    tick(3);
    chk(12'h100, 32'h1, "R2 hold lo");
    chk(12'h104, 32'h1, "R2 hold hi");

    wr(12'h100, 32'hFFFF_FFFF); wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h240, 32'h100);
    tick();
    chk(12'h100, 32'h0, "R2 wrap lo");
    chk(12'h104, 32'h0, "R2 wrap hi");

    wr(12'h24C, 32'h0001_0007); tick();
    wr(12'h240, 32'h0);
    wr(12'h100, 0); wr(12'h104, 0);
    wr(12'h200, 32'd10); wr(12'h204, 0);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h100);
    tick(15);
    chk(12'h244, 32'h0, "R4 disabled compare no pend");
    tick();
    chk(12'h24C, 32'h0001_0003, "R8 gws bits");
    wr(12'h240, 32'h0);
    wr(12'h100, 0);
    wr(12'h240, 32'h101);
    tick(10);
    chk(12'h244, 32'h0, "R4 before match");
    chk_irq(1'b0, "R7 irq before match");
    tick();
    chk(12'h244, 32'h1, "R4 pend on match");
    chk_irq(1'b1, "R7 irq on match");
    wr(12'h248, 32'h0);
    chk_irq(1'b0, "R7 irq masked");
    wr(12'h244, 32'h0);
    chk(12'h244, 32'h1, "R6 write 0 keeps pend");
    wr(12'h244, 32'h1);
    chk(12'h244, 32'h0, "R6 pend cleared");

    wr(12'h240, 32'h0);
    wr(12'h100, 0);
    wr(12'h200, 32'd5);
    wr(12'h208, 32'd7);
    wr(12'h240, 32'h103);
    tick(6);
    chk(12'h244, 32'h1, "R5 first match");
    chk(12'h200, 32'd12, "R5 cmp advanced");
    wr(12'h244, 32'h1);
    tick(5);
    chk(12'h244, 32'h0, "R5 before second match");
    tick();
    chk(12'h244, 32'h1, "R5 second match");
    chk(12'h200, 32'd19, "R5 cmp advanced again");

    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    wr(12'h100, 32'hFFFF_FFFC); wr(12'h104, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFE); wr(12'h204, 32'hFFFF_FFFF);
    wr(12'h208, 32'd4);
    wr(12'h240, 32'h103);
    tick(3);
    chk(12'h244, 32'h1, "R5 match near top");
    chk(12'h200, 32'h2, "R5 cmp wrap lo");
    chk(12'h204, 32'h0, "R5 cmp wrap hi");

    wr(12'h240, 32'h102);
    chk(12'h240, 32'h102, "R10 ctl readback");
    wr(12'h240, 32'hFFFF_FEFC);
    chk(12'h240, 32'h0, "R10 ctl unused bits");
    chk(12'h208, 32'd4, "R10 step readback");
    wr(12'h300, 32'h5A);
    chk(12'h300, 32'h0, "R10 unmapped reads 0");
    chk(12'h240, 32'h0, "R10 unmapped write ignored");

    wait (act_q.size() == 0);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule